// File: doc/BRIEF.md
# Pipeline Stall and Flush Cycle Accounting

This block sits beside a pipelined core and classifies every clock cycle. Each cycle it receives an encoded stall reason, four flush strobes, an active qualifier (high while the core is neither in reset nor halted) and the phase flags of the instruction-side and data-side second-level cache miss engines. It keeps one saturating counter per stall reason, one per flush category, two counters of coinciding events, an active-cycle denominator and a separate count of cycles spent in miss service.

The miss-service count is gathered on its own. It does not depend on the stall reason or on the active qualifier, and it is never folded into the stall totals. A build without a second-level cache sets `HAS_L2` to zero, which ties the aggregated busy flag low. Software or a trace harness reads any counter through an indexed port with one cycle of latency. A single synchronous strobe clears all counters.

Top module: `perf_cycle_acct`

## Requirements
- R1: After reset every counter is zero and the read data output is zero.
- R2: Counter index 0 (active cycles) increments in every cycle where `active_i` is high.
- R3: For a stall code c in 1..N_CAUSE-1, counter index c increments in each active cycle where `cause_i` equals c. Code 0 means no stall and increments no stall counter.
- R4: Flush bit 0 (trap), bit 1 (instruction fence), bit 2 (branch-predictor redirect) and bit 3 (execute-stage flush) each increment counter index N_CAUSE plus the bit number (8..11 by default) in active cycles.
- R5: Counter index N_CAUSE+4 (12) increments in active cycles where two or more flush bits are high together.
- R6: Counter index N_CAUSE+5 (13) increments in active cycles where a nonzero stall code coincides with at least one flush bit.
- R7: While `active_i` is low, counters 0 through N_CAUSE+5 do not change, whatever the stall code and flush bits are.
- R8: Counter index N_CAUSE+6 (14) increments in any cycle where any of the four phase flags of either miss engine is high (bit 0 tracker allocation, bit 1 victim writeback, bit 2 fill wait, bit 3 fill write). This holds regardless of `active_i` and `cause_i`, and the miss flags change no other counter.
- R9: With `HAS_L2` = 0 the miss counter stays at zero whatever the phase flags are.
- R10: Each counter is CNT_W bits wide (default 32) and holds at all-ones instead of wrapping.
- R11: `clr_i` zeroes every counter at the next clock edge and takes priority over an increment in the same cycle.
- R12: `rd_data_o` presents, one cycle after `rd_idx_i` is sampled, the value the indexed counter held before that edge. An index of N_CNT or above returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| active_i | input | 1 | Core running (not in reset, not halted) |
| cause_i | input | log2(N_CAUSE) (3) | Encoded stall reason, 0 = none |
| flush_i | input | 4 | Flush strobes: trap, fence, predictor redirect, execute flush |
| imiss_phase_i | input | 4 | Instruction-side miss engine phase flags |
| dmiss_phase_i | input | 4 | Data-side miss engine phase flags |
| clr_i | input | 1 | Synchronous clear of all counters |
| rd_idx_i | input | log2(N_CNT) (4) | Counter select for reading |
| rd_data_o | output | CNT_W (32) | Registered counter value |

## Verification
The bench drives miss phases while the core is inactive and while stall codes are reported. A design that gated the miss counter with the active flag, or that added miss cycles into a stall bucket, would show a miscompare on index 14 or on the stall indices. It raises several flush bits together and mixes them with stall codes, which exposes a wrong overlap threshold or an overlap counter that ignores the stall code. A read issued in the same cycle as a clear must return the pre-clear value, and a design that let an increment win over a clear would leave nonzero counts behind. A long burst on a narrowed counter would show wrap-around as a small value where all-ones is expected. A second instance built without the cache has to keep its miss count at zero.

// File: rtl/perf_pkg.sv
package perf_pkg;
    // flush strobe bit positions (the decoder depends on this order)
    localparam int FL_TRAP  = 0;
    localparam int FL_FENCE = 1;
    localparam int FL_BPRED = 2;
    localparam int FL_EXEC  = 3;
    localparam int N_FLUSH  = 4;

    // miss engine phase flags
    localparam int PH_ALLOC = 0;
    localparam int PH_VICWB = 1;
    localparam int PH_WAIT  = 2;
    localparam int PH_FILL  = 3;
    localparam int N_PHASE  = 4;

    // extra counters after the stall and flush groups
    localparam int N_EXTRA  = 3;
endpackage

// File: rtl/perf_miss_busy.sv
module perf_miss_busy #(
    parameter bit HAS_L2 = 1'b1
) (
    input  logic [perf_pkg::N_PHASE-1:0] imiss_phase_i,
    input  logic [perf_pkg::N_PHASE-1:0] dmiss_phase_i,
    output logic                         busy_o
);
    logic side_busy;

    always_comb begin
        side_busy = (|imiss_phase_i) | (|dmiss_phase_i);
    end

    generate
        if (HAS_L2) begin : g_l2
            assign busy_o = side_busy;
        end else begin : g_nol2
            logic unused_busy;
            assign unused_busy = side_busy;
            assign busy_o      = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/perf_event_decode.sv
module perf_event_decode #(
    parameter int N_CAUSE = 8,
    localparam int CW     = $clog2(N_CAUSE),
    localparam int N_CNT  = N_CAUSE + perf_pkg::N_FLUSH + perf_pkg::N_EXTRA
) (
    input  logic                         active_i,
    input  logic [CW-1:0]                cause_i,
    input  logic [perf_pkg::N_FLUSH-1:0] flush_i,
    input  logic                         miss_busy_i,
    output logic [N_CNT-1:0]             inc_o
);
    import perf_pkg::*;

    localparam int NFW      = $clog2(N_FLUSH + 1);
    localparam int IDX_FL   = N_CAUSE;
    localparam int IDX_OVF  = N_CAUSE + N_FLUSH;
    localparam int IDX_OVS  = IDX_OVF + 1;
    localparam int IDX_MISS = IDX_OVF + 2;

    logic [NFW-1:0] n_flush;
    logic           any_stall;

    always_comb begin
        n_flush = '0;
        for (int f = 0; f < N_FLUSH; f++) begin
            n_flush = n_flush + NFW'(flush_i[f]);
        end
        any_stall = (cause_i != '0);

        inc_o    = '0;
        inc_o[0] = active_i;
        for (int c = 1; c < N_CAUSE; c++) begin
            inc_o[c] = active_i && (cause_i == CW'(c));
        end
        for (int f = 0; f < N_FLUSH; f++) begin
            inc_o[IDX_FL+f] = active_i && flush_i[f];
        end
        inc_o[IDX_OVF]  = active_i && (n_flush >= NFW'(2));
        inc_o[IDX_OVS]  = active_i && any_stall && (|flush_i);
        inc_o[IDX_MISS] = miss_busy_i;
    end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
    parameter int CNT_W = 32,
    parameter int N_CNT = 15,
    localparam int IDX_W = $clog2(N_CNT)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_CNT-1:0] inc_i,
    input  logic             clr_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [CNT_W-1:0] rd_data_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [N_CNT-1:0][CNT_W-1:0] cnt;
        logic [CNT_W-1:0]            rd;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < N_CNT; k++) begin
            if (clr_i) begin
                s_d.cnt[k] = '0;
            end else if (inc_i[k] && (s_q.cnt[k] != CNT_MAX)) begin
                s_d.cnt[k] = s_q.cnt[k] + CNT_W'(1);
            end
        end
        s_d.rd = '0;
        for (int k = 0; k < N_CNT; k++) begin
            if (rd_idx_i == IDX_W'(k)) begin
                s_d.rd = s_q.cnt[k];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data_o = s_q.rd;

    // R11
    clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (s_q.cnt == '0));

    generate
        for (genvar k = 0; k < N_CNT; k++) begin : g_chk
            // R10
            sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!clr_i && s_q.cnt[k] == CNT_MAX) |=> (s_q.cnt[k] == CNT_MAX));
            // R2
            unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !clr_i |=> (s_q.cnt[k] == $past(s_q.cnt[k]) ||
                            s_q.cnt[k] == $past(s_q.cnt[k]) + CNT_W'(1)));
            // R7
            idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!clr_i && !inc_i[k]) |=> $stable(s_q.cnt[k]));
        end
    endgenerate
endmodule

// File: rtl/perf_cycle_acct.sv
module perf_cycle_acct #(
    parameter int CNT_W   = 32,
    parameter int N_CAUSE = 8,
    parameter bit HAS_L2  = 1'b1,
    localparam int CW     = $clog2(N_CAUSE),
    localparam int N_CNT  = N_CAUSE + perf_pkg::N_FLUSH + perf_pkg::N_EXTRA,
    localparam int IDX_W  = $clog2(N_CNT)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         active_i,
    input  logic [CW-1:0]                cause_i,
    input  logic [perf_pkg::N_FLUSH-1:0] flush_i,
    input  logic [perf_pkg::N_PHASE-1:0] imiss_phase_i,
    input  logic [perf_pkg::N_PHASE-1:0] dmiss_phase_i,
    input  logic                         clr_i,
    input  logic [IDX_W-1:0]             rd_idx_i,
    output logic [CNT_W-1:0]             rd_data_o
);
    localparam int IDX_MISS = N_CNT - 1;

    logic             miss_busy;
    logic [N_CNT-1:0] inc;

    perf_miss_busy #(.HAS_L2(HAS_L2)) u_miss (
        .imiss_phase_i(imiss_phase_i),
        .dmiss_phase_i(dmiss_phase_i),
        .busy_o       (miss_busy)
    );

    perf_event_decode #(.N_CAUSE(N_CAUSE)) u_dec (
        .active_i   (active_i),
        .cause_i    (cause_i),
        .flush_i    (flush_i),
        .miss_busy_i(miss_busy),
        .inc_o      (inc)
    );

    perf_counter_bank #(.CNT_W(CNT_W), .N_CNT(N_CNT)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .inc_i    (inc),
        .clr_i    (clr_i),
        .rd_idx_i (rd_idx_i),
        .rd_data_o(rd_data_o)
    );

    // R7
    inactive_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_i |-> (inc[IDX_MISS-1:0] == '0));

    // R8
    miss_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (HAS_L2 && ((|imiss_phase_i) || (|dmiss_phase_i))) |-> inc[IDX_MISS]);
endmodule

// File: tb/perf_cycle_acct_bench.sv
`timescale 1ns/1ps
module perf_cycle_acct_bench;
    localparam int W     = 8;
    localparam int NC    = 15;
    localparam int unsigned MAXV = 255;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       active = 1'b0;
    logic [2:0] cause = '0;
    logic [3:0] flush = '0;
    logic [3:0] iph = '0;
    logic [3:0] dph = '0;
    logic       clr = 1'b0;
    logic [3:0] idx = '0;
    logic [W-1:0] rd_a, rd_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    perf_cycle_acct #(.CNT_W(W), .N_CAUSE(8), .HAS_L2(1'b1)) u_perf_cycle_acct (
        .clk_i(clk), .rst_ni(rst_ni), .active_i(active), .cause_i(cause),
        .flush_i(flush), .imiss_phase_i(iph), .dmiss_phase_i(dph),
        .clr_i(clr), .rd_idx_i(idx), .rd_data_o(rd_a));

    perf_cycle_acct #(.CNT_W(W), .N_CAUSE(8), .HAS_L2(1'b0)) u_perf_cycle_acct_nol2 (
        .clk_i(clk), .rst_ni(rst_ni), .active_i(active), .cause_i(cause),
        .flush_i(flush), .imiss_phase_i(iph), .dmiss_phase_i(dph),
        .clr_i(clr), .rd_idx_i(idx), .rd_data_o(rd_b));

    typedef struct {
        int unsigned ea;
        int unsigned eb;
        int          ix;
        string       tag;
    } item_t;

    item_t       sb[$];
    int unsigned mod_a[NC];
    int unsigned mod_b[NC];

    function automatic string tag_of(int i);
        if (i == 0)  return "R2";
        if (i < 8)   return "R3";
        if (i < 12)  return "R4";
        if (i == 12) return "R5";
        if (i == 13) return "R6";
        if (i == 14) return "R8";
        return "R12";
    endfunction

    function automatic void model_tick(bit a, int c, logic [3:0] f,
                                       logic [3:0] ip, logic [3:0] dp, bit cl);
        bit ev[NC];
        int nf = 0;
        for (int i = 0; i < NC; i++) ev[i] = 0;
        for (int b = 0; b < 4; b++) if (f[b]) nf++;
        ev[0] = a;
        if (a && c != 0) ev[c] = 1;
        for (int b = 0; b < 4; b++) if (a && f[b]) ev[8+b] = 1;
        ev[12] = a && (nf > 1);
        ev[13] = a && (c != 0) && (nf > 0);
        ev[14] = (ip != 0) || (dp != 0);
        for (int i = 0; i < NC; i++) begin
            if (cl) begin
                mod_a[i] = 0;
                mod_b[i] = 0;
            end else if (ev[i]) begin
                if (mod_a[i] < MAXV) mod_a[i]++;
                if (i != 14 && mod_b[i] < MAXV) mod_b[i]++;
            end
        end
    endfunction

    task automatic step(bit a, int c, logic [3:0] f, logic [3:0] ip,
                        logic [3:0] dp, bit cl, int ix, string ctx);
        item_t it;
        @(negedge clk);
        active = a; cause = 3'(c); flush = f; iph = ip; dph = dp;
        clr = cl; idx = 4'(ix);
        it.ea  = (ix < NC) ? mod_a[ix] : 0;
        it.eb  = (ix < NC) ? mod_b[ix] : 0;
        it.ix  = ix;
        it.tag = {ctx, "/", tag_of(ix)};
        sb.push_back(it);
        model_tick(a, c, f, ip, dp, cl);
    endtask

    // monitor: one result per clock edge after a driven step
    always @(posedge clk) begin
        item_t it;
        #1;
        if (sb.size() > 0 && !done) begin
            it = sb.pop_front();
            checks++;
            if (int'(rd_a) != int'(it.ea)) begin
                fails++;
                $display("FAIL %s idx=%0d actual=%0d expected=%0d", it.tag, it.ix, rd_a, it.ea);
            end
            checks++;
            if (int'(rd_b) != int'(it.eb)) begin
                fails++;
                $display("FAIL R9 %s no-cache idx=%0d actual=%0d expected=%0d", it.tag, it.ix, rd_b, it.eb);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            mod_a[i] = 0;
            mod_b[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_ni = 1'b1;

        // R1 reset state, and R12 out-of-range index
        for (int i = 0; i < 16; i++) step(0, 0, 4'h0, 4'h0, 4'h0, 0, i, "R1");
        // R2 R3 stall codes while active
        for (int i = 0; i < 40; i++) step(1, i % 8, 4'h0, 4'h0, 4'h0, 0, (i + 3) % 15, "R3");
        // R4 R5 R6 flush combinations mixed with stall codes
        for (int i = 0; i < 48; i++)
            step(1, (i % 3 == 0) ? i % 8 : 0, 4'(i % 16), 4'h0, 4'h0, 0, 8 + i % 6, "R4");
        // R7 inactive cycles leave counters alone
        for (int i = 0; i < 24; i++) step(0, i % 8, 4'(i % 16), 4'h0, 4'h0, 0, i % 14, "R7");
        // R8 R9 miss phases, independent of active and stall code
        for (int i = 0; i < 32; i++)
            step(i % 2 == 1, i % 8, 4'h0,
                 (i % 3 == 0) ? 4'(1 << (i % 4)) : 4'h0,
                 (i % 3 == 1) ? 4'(1 << ((i + 1) % 4)) : 4'h0,
                 0, (i % 2 == 1) ? 14 : i % 14, "R8");
        // R12 read in the clear cycle returns the old value; R11 then zeros
        step(1, 3, 4'b0101, 4'b0001, 4'h0, 1, 3, "R11");
        for (int i = 0; i < 16; i++) step(0, 0, 4'h0, 4'h0, 4'h0, 0, i, "R11");
        // R10 long burst saturates the narrowed counters
        for (int i = 0; i < 300; i++) step(1, 1, 4'b0011, 4'b0001, 4'h0, 0, i % 16, "R10");
        for (int i = 0; i < 16; i++) step(0, 0, 4'h0, 4'h0, 4'h0, 0, i, "R10");
        // R11 clear with increment pending in the same cycle
        step(1, 2, 4'b1111, 4'b1000, 4'b1000, 1, 14, "R11");
        for (int i = 0; i < 16; i++) step(0, 0, 4'h0, 4'h0, 4'h0, 0, i, "R11");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule